// File: doc/BRIEF.md
# Two-Digit Elapsed-Seconds Timer with Stop at Sixty

This block counts elapsed seconds on two decimal digits, starting at 00 and advancing once for each one-cycle tick pulse that an outside divider supplies. The units digit runs 0 through 9. When it rolls over from 9 to 0, a one-cycle carry advances the tens digit. The tens digit counts from 0 to 6 and never wraps. When the display shows 60 the units digit is no longer allowed to count, so the timer freezes and a done flag is raised.

Each digit is also turned into an active-high pattern for a common-cathode seven-segment display. The host can zero both digits at once with a synchronous clear input. An asynchronous active-low reset puts the block into the same 00 state at power-up.

Top module: `sec_timer60`

## Requirements
- R1: The units digit takes only the values 0 to 9. A tick while the units digit is 9 (and the count is below 60) sets it to 0 at the next clock edge. Any other accepted tick adds one.
- R2: The tens digit changes only on a units rollover (9 to 0), and then it goes up by exactly one.
- R3: The tens digit never goes above 6 and never wraps from 6 back to 0.
- R4: `done` is 1 exactly while the digits read tens=6, units=0. Ticks that arrive while `done` is 1 leave both digits unchanged.
- R5: When `clr`=1 at a clock edge, both digits become 0 at that edge, even if `tick` is also 1.
- R6: When `rst_n`=0, both digits go to 0 and `done` goes to 0 without waiting for a clock edge.
- R7: The segment outputs are ordered {g,f,e,d,c,b,a} and are active high. The patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F in hex.
- R8: When `tick`=0 and `clr`=0, the digits hold their values.
- R9: A single tick at 59 gives 60 at the next edge, with no state in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable, nominally once per second |
| clr | input | 1 | Synchronous clear of both digits, active high |
| units_bcd | output | 4 | Units digit, BCD |
| tens_bcd | output | 4 | Tens digit, BCD |
| seg_units | output | 7 | Units segment pattern {g,f,e,d,c,b,a} |
| seg_tens | output | 7 | Tens segment pattern {g,f,e,d,c,b,a} |
| done | output | 1 | High while the count reads 60 |

## Verification
A run of 70 consecutive ticks is compared value by value against a decimal model. This run covers every units rollover, the 59-to-60 step and ten ignored ticks at 60, so it can tell a design that wraps or overshoots apart from one that freezes correctly. Idle gaps with no tick catch a design that counts without an enable. A clear that arrives on the same cycle as a tick, and an asynchronous reset in the middle of a count, show whether the clear takes priority over counting and whether the reset reaches both digits.

// File: rtl/sec_timer60_pkg.sv
package sec_timer60_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/st60_units.sv
module st60_units
  import sec_timer60_pkg::*;
#(
  parameter int LAST = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output bcd_t q_o,
  output logic carry_o
);
  localparam bcd_t LAST_V = bcd_t'(LAST);

  bcd_t q_r, q_nxt;
  logic at_last;

  always_comb begin
    at_last = (q_r == LAST_V);
    carry_o = en_i && at_last && !clr_i;
    q_nxt   = q_r;
    if (clr_i)        q_nxt = '0;
    else if (en_i)    q_nxt = at_last ? '0 : q_r + bcd_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  p_units_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    q_r <= LAST_V);
  p_units_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && q_r == LAST_V) |=> (q_r == '0));
  p_units_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(q_r));
endmodule

// File: rtl/st60_tens.sv
module st60_tens
  import sec_timer60_pkg::*;
#(
  parameter int LAST = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic carry_i,
  output bcd_t q_o,
  output logic full_o
);
  localparam bcd_t LAST_V = bcd_t'(LAST);

  bcd_t q_r, q_nxt;

  always_comb begin
    full_o = (q_r == LAST_V);
    q_nxt  = q_r;
    if (clr_i)                   q_nxt = '0;
    else if (carry_i && !full_o) q_nxt = q_r + bcd_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  p_tens_only_on_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !carry_i) |=> $stable(q_r));
  p_tens_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_r <= LAST_V);
endmodule

// File: rtl/st60_seg.sv
module st60_seg
  import sec_timer60_pkg::*;
(
  input  bcd_t bcd_i,
  output seg_t seg_o
);
  always_comb begin
    unique case (bcd_i)
      4'd0:    seg_o = 7'h3F;
      4'd1:    seg_o = 7'h06;
      4'd2:    seg_o = 7'h5B;
      4'd3:    seg_o = 7'h4F;
      4'd4:    seg_o = 7'h66;
      4'd5:    seg_o = 7'h6D;
      4'd6:    seg_o = 7'h7D;
      4'd7:    seg_o = 7'h07;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h6F;
      default: seg_o = 7'h00;
    endcase
  end
endmodule

// File: rtl/sec_timer60.sv
module sec_timer60
  import sec_timer60_pkg::*;
#(
  parameter int UNITS_LAST = 9,
  parameter int TENS_LAST  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  output logic [3:0] units_bcd,
  output logic [3:0] tens_bcd,
  output logic [6:0] seg_units,
  output logic [6:0] seg_tens,
  output logic       done
);
  bcd_t u_q, t_q;
  logic carry, tens_full, units_en;

  assign units_en = tick && !tens_full;

  st60_units #(.LAST(UNITS_LAST)) u_units (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(units_en),
    .q_o(u_q), .carry_o(carry)
  );

  st60_tens #(.LAST(TENS_LAST)) u_tens (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .carry_i(carry),
    .q_o(t_q), .full_o(tens_full)
  );

  st60_seg u_seg_u (.bcd_i(u_q), .seg_o(seg_units));
  st60_seg u_seg_t (.bcd_i(t_q), .seg_o(seg_tens));

  assign units_bcd = u_q;
  assign tens_bcd  = t_q;
  assign done      = tens_full;

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> ($stable(u_q) && $stable(t_q) && done));
  p_done_zero_units_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (u_q == '0));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (u_q == '0 && t_q == '0));
endmodule

// File: tb/sim_sec_timer60.sv
module sim_sec_timer60;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, clr = 1'b0;
  logic [3:0] units_bcd, tens_bcd;
  logic [6:0] seg_units, seg_tens;
  logic done;
  int n_cmp = 0, n_bad = 0, m_u = 0, m_t = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sec_timer60 u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr),
    .units_bcd(units_bcd), .tens_bcd(tens_bcd), .seg_units(seg_units),
    .seg_tens(seg_tens), .done(done));

  function automatic logic [6:0] pat(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, int'(units_bcd), m_u);
    chk(req, int'(tens_bcd), m_t);
    chk({req, "/done"}, int'(done), int'(m_t == 6 && m_u == 0));
    chk("R7 seg_units", int'(seg_units), int'(pat(m_u)));
    chk("R7 seg_tens", int'(seg_tens), int'(pat(m_t)));
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (m_t != 6) begin
      if (m_u == 9) begin m_u = 0; m_t++; end
      else m_u++;
    end
  endtask

  task automatic t_reset();
    #1; chk("R6 reset units", int'(units_bcd), 0);
    chk("R6 reset tens", int'(tens_bcd), 0);
    chk("R6 reset done", int'(done), 0);
    @(negedge clk) rst_n = 1'b1;
    chk_all("R6 after release");
  endtask

  task automatic t_idle();
    do_tick(); do_tick(); do_tick();
    repeat (5) @(negedge clk);
    chk_all("R8 idle hold");
  endtask

  task automatic t_run70();
    for (int i = 0; i < 70; i++) begin
      do_tick();
      if (m_t == 6 && m_u == 0 && i < 60) chk_all("R9 59 to 60");
      else if (m_u == 0) chk_all("R2 R1 rollover");
      else chk_all("R1 R3 R4 count");
    end
    chk(" R4 frozen at 60", int'(tens_bcd)*10 + int'(units_bcd), 60);
  endtask

  task automatic t_clr_tick();
    @(negedge clk) begin clr = 1'b1; tick = 1'b1; end
    @(negedge clk) begin clr = 1'b0; tick = 1'b0; end
    m_u = 0; m_t = 0;
    chk_all("R5 clr beats tick");
    for (int i = 0; i < 23; i++) do_tick();
    chk_all("R2 count after clr");
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    m_u = 0; m_t = 0;
    chk_all("R5 clr mid count");
  endtask

  task automatic t_async();
    for (int i = 0; i < 17; i++) do_tick();
    chk_all("R1 before async reset");
    #1.2 rst_n = 1'b0;
    #0.5;
    m_u = 0; m_t = 0;
    chk_all("R6 async mid count");
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_idle();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    m_u = 0; m_t = 0;
    t_run70();
    t_clr_tick();
    t_async();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule